// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

A bank of up to 32 general-purpose lines controlled through a word-wide register bus. Each line is independently a driven output, a plain input, or an interrupt source. Interrupt sources sample their pin through a two-flop synchroniser. Per-line settings choose the sense mode for each source: active level, a single edge of chosen polarity, or any transition.

Each line latches its own interrupt status. Software acknowledges a line by writing a one to its bit in the clear register. The enable mask is changed through two registers. One disables every line written as zero. The other enables every line written as one. A single request output stays high while any line is both pending and enabled.

Each interrupt line runs a per-line sense selector that decodes its configuration into one of three named modes. The mode `SENSE_LEVEL` applies when the edge bit is 0. `SENSE_ONE_EDGE` applies when the edge bit is 1 and the both-edge bit is 0. `SENSE_BOTH_EDGE` applies when both bits are 1. The mode changes whenever software rewrites those two bits. The only other transition is to the idle condition: a line whose source-select bit is 0 holds its status at zero.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0, so each line is a masked input.
- R2: Registers live at byte offsets 0x00 source select, 0x04 direction, 0x08 output data, 0x0C input data, 0x10 status, 0x14 clear, 0x18 mask, 0x1C unmask, 0x20 polarity, 0x24 edge select, 0x28 filter enable and 0x4C both-edge, with bit i belonging to line i. The select, direction, output data, polarity, edge, both-edge and filter registers read back what was written.
- R3: `pin_oe[i]` is 1 exactly when the direction bit is 1 and the source-select bit is 0, and `pin_out` equals the output data register. The input data register returns the pin value two clocks after it changes.
- R4: A write to 0x18 disables every line whose written bit is 0 and leaves the others unchanged. A write to 0x1C enables every line whose written bit is 1. Reading 0x18 returns 1 for enabled lines.
- R5: In level mode (edge bit 0) the status follows the pin: it is 1 while the pin is high when the polarity bit is 1, and 1 while the pin is low when the polarity bit is 0. A clear has no effect while the level persists.
- R6: In single-edge mode (edge bit 1, both-edge bit 0), a rising edge sets the status when the polarity bit is 1, and a falling edge sets it when the polarity bit is 0. The status is visible three clocks after the pin changes and stays set until it is cleared.
- R7: With the edge bit and the both-edge bit both 1, every transition sets the status, regardless of polarity.
- R8: Writing 1 to a bit of 0x14 clears that line's edge status, and bits written as 0 do nothing. If a new edge arrives in the same cycle as the clear, the status stays set.
- R9: `irq` is 1 exactly while the status AND the mask is nonzero.
- R10: A line whose source-select bit is 0 never shows status, whatever its pin does.
- R11: The filter-enable register stores its value but changes no behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin levels |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin drive enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The case that needs care is an edge that reaches the detector in the same cycle that software writes a one to the clear register for that line. The bench places the pin change two clocks before the clock that samples the clear write. At that point the synchronised edge and the acknowledge are present on the same clock edge, and the status must still read 1 afterwards. A control run then issues the same clear with no new edge and expects the status to drop to 0, which shows that the clear itself works.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFS_SRCSEL = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 7'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_UNMASK = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_POL    = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_EDGE   = 7'h24;
    localparam logic [ADDR_W-1:0] OFS_FILT   = 7'h28;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 7'h4C;

    typedef enum logic [1:0] {
        SENSE_LEVEL     = 2'd0,
        SENSE_ONE_EDGE  = 2'd1,
        SENSE_BOTH_EDGE = 2'd2
    } sense_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/gpb_line_detect.sv
module gpb_line_detect
    import gpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_i,
    input  logic act_i,
    input  logic pol_i,
    input  logic edg_i,
    input  logic both_i,
    input  logic clr_i,
    output logic st_o
);
    logic   prev_q;
    logic   st_q;
    logic   st_d;
    logic   hit;
    sense_e mode;

    always_comb begin
        if (!edg_i)      mode = SENSE_LEVEL;
        else if (both_i) mode = SENSE_BOTH_EDGE;
        else             mode = SENSE_ONE_EDGE;
    end

    always_comb begin
        hit  = 1'b0;
        st_d = 1'b0;
        unique case (mode)
            SENSE_LEVEL: begin
                st_d = pol_i ? s_i : ~s_i;
            end
            SENSE_ONE_EDGE: begin
                hit  = pol_i ? (s_i & ~prev_q) : (~s_i & prev_q);
                st_d = hit | (st_q & ~clr_i);
            end
            SENSE_BOTH_EDGE: begin
                hit  = s_i ^ prev_q;
                st_d = hit | (st_q & ~clr_i);
            end
            default: st_d = 1'b0;
        endcase
        if (!act_i) st_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            st_q   <= 1'b0;
        end else begin
            prev_q <= s_i;
            st_q   <= st_d;
        end
    end

    assign st_o = st_q;

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q && act_i && edg_i && !clr_i) |=> st_q); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && edg_i && clr_i && !hit) |=> !st_q); // R8
    AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && edg_i && clr_i && hit) |=> st_q); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> !st_q); // R10
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic [N-1:0]      pins_i,
    input  logic [N-1:0]      stat_i,
    output logic [N-1:0]      rdata_o,
    output logic [N-1:0]      srcsel_o,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      dout_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      edge_o,
    output logic [N-1:0]      both_o,
    output logic [N-1:0]      clr_o
);
    logic [N-1:0] srcsel_q, dir_q, dout_q, mask_q, pol_q, edge_q, both_q, filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srcsel_q <= '0;
            dir_q    <= '0;
            dout_q   <= '0;
            mask_q   <= '0;
            pol_q    <= '0;
            edge_q   <= '0;
            both_q   <= '0;
            filt_q   <= '0;
        end else if (wr_i) begin
            case (addr_i)
                OFS_SRCSEL: srcsel_q <= wdata_i;
                OFS_DIR:    dir_q    <= wdata_i;
                OFS_DOUT:   dout_q   <= wdata_i;
                OFS_MASK:   mask_q   <= mask_q & wdata_i;
                OFS_UNMASK: mask_q   <= mask_q | wdata_i;
                OFS_POL:    pol_q    <= wdata_i;
                OFS_EDGE:   edge_q   <= wdata_i;
                OFS_FILT:   filt_q   <= wdata_i;
                OFS_BOTH:   both_q   <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr_i)
            OFS_SRCSEL: rdata_o = srcsel_q;
            OFS_DIR:    rdata_o = dir_q;
            OFS_DOUT:   rdata_o = dout_q;
            OFS_DIN:    rdata_o = pins_i;
            OFS_STAT:   rdata_o = stat_i;
            OFS_MASK:   rdata_o = mask_q;
            OFS_POL:    rdata_o = pol_q;
            OFS_EDGE:   rdata_o = edge_q;
            OFS_FILT:   rdata_o = filt_q;
            OFS_BOTH:   rdata_o = both_q;
            default:    rdata_o = '0;
        endcase
    end

    assign clr_o    = (wr_i && addr_i == OFS_CLR) ? wdata_i : '0;
    assign srcsel_o = srcsel_q;
    assign dir_o    = dir_q;
    assign dout_o   = dout_q;
    assign mask_o   = mask_q;
    assign pol_o    = pol_q;
    assign edge_o   = edge_q;
    assign both_o   = both_q;

    AST_MASK_ZERO_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_MASK) |=> (mask_q & ~$past(wdata_i)) == '0); // R4
    AST_UNMASK_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_UNMASK) |=> (mask_q & $past(wdata_i)) == $past(wdata_i)); // R4
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpb_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic              irq
);
    logic [N-1:0] pins_s, stat, srcsel, dir, dout, mask, pol, edg, both, clr;

    gpb_sync #(.W(N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (pins_s)
    );

    gpb_regs #(.N(N)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .pins_i   (pins_s),
        .stat_i   (stat),
        .rdata_o  (bus_rdata),
        .srcsel_o (srcsel),
        .dir_o    (dir),
        .dout_o   (dout),
        .mask_o   (mask),
        .pol_o    (pol),
        .edge_o   (edg),
        .both_o   (both),
        .clr_o    (clr)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        gpb_line_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .s_i    (pins_s[i]),
            .act_i  (srcsel[i]),
            .pol_i  (pol[i]),
            .edg_i  (edg[i]),
            .both_i (both[i]),
            .clr_i  (clr[i]),
            .st_o   (stat[i])
        );
    end

    assign pin_out = dout;
    assign pin_oe  = dir & ~srcsel;
    assign irq     = |(stat & mask);

    AST_OE_NOT_ON_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & srcsel) == '0); // R3
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        pin_in = '0;
        bus_wr = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(7'h00, d); chk(d, 0, "R1 srcsel");
        rd(7'h04, d); chk(d, 0, "R1 dir");
        rd(7'h18, d); chk(d, 0, "R1 mask");
        rd(7'h10, d); chk(d, 0, "R1 status");
        chk(pin_oe, 0, "R1 pin_oe");
        chk({31'd0, irq}, 0, "R1 irq");
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_reset();
        wr(7'h20, 32'h1234_5678); rd(7'h20, d); chk(d, 32'h1234_5678, "R2 polarity");
        wr(7'h24, 32'h0F0F_0000); rd(7'h24, d); chk(d, 32'h0F0F_0000, "R2 edge");
        wr(7'h4C, 32'hA5A5_0000); rd(7'h4C, d); chk(d, 32'hA5A5_0000, "R2 both");
        wr(7'h08, 32'hCAFE_0001); rd(7'h08, d); chk(d, 32'hCAFE_0001, "R2 dout");
    endtask

    task automatic t_io();
        logic [31:0] d;
        do_reset();
        wr(7'h04, 32'h0000_00F0);
        wr(7'h08, 32'h0000_00A0);
        chk(pin_oe, 32'h0000_00F0, "R3 oe");
        chk(pin_out, 32'h0000_00A0, "R3 out");
        wr(7'h24, 32'h10); wr(7'h00, 32'h10);
        chk(pin_oe, 32'h0000_00E0, "R3 oe off for source");
        pin_in = 32'h8000_0001;
        cyc(1); rd(7'h0C, d); chk(d, 0, "R3 input not yet");
        cyc(1); rd(7'h0C, d); chk(d, 32'h8000_0001, "R3 input after two clocks");
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        wr(7'h1C, 32'h0F); rd(7'h18, d); chk(d, 32'h0F, "R4 unmask");
        wr(7'h18, 32'hFFFF_FFF5); rd(7'h18, d); chk(d, 32'h05, "R4 mask zeros");
        wr(7'h1C, 32'h0); rd(7'h18, d); chk(d, 32'h05, "R4 unmask zero no effect");
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        wr(7'h1C, 32'h2);
        wr(7'h00, 32'h2);
        cyc(1);
        rd(7'h10, d); chk(d, 32'h2, "R5 active-low level");
        chk({31'd0, irq}, 1, "R9 irq with level");
        wr(7'h14, 32'h2); rd(7'h10, d); chk(d, 32'h2, "R5 clear ignored");
        pin_in[1] = 1'b1; cyc(3);
        rd(7'h10, d); chk(d, 0, "R5 level gone");
        chk({31'd0, irq}, 0, "R9 irq low");
        wr(7'h20, 32'h2); cyc(1);
        rd(7'h10, d); chk(d, 32'h2, "R5 active-high level");
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        wr(7'h24, 32'h5); wr(7'h20, 32'h1);
        wr(7'h00, 32'h5); wr(7'h1C, 32'h1);
        pin_in[0] = 1'b1;
        cyc(2); rd(7'h10, d); chk(d, 0, "R6 latency not yet");
        cyc(1); rd(7'h10, d); chk(d, 32'h1, "R6 rising after three clocks");
        pin_in[0] = 1'b0; cyc(4);
        rd(7'h10, d); chk(d, 32'h1, "R6 sticky");
        chk({31'd0, irq}, 1, "R9 irq edge");
        pin_in[2] = 1'b1; cyc(4);
        rd(7'h10, d); chk(d, 32'h1, "R6 rising ignored by falling line");
        pin_in[2] = 1'b0; cyc(4);
        rd(7'h10, d); chk(d, 32'h5, "R6 falling");
        wr(7'h14, 32'h1); rd(7'h10, d); chk(d, 32'h4, "R8 clear one bit");
        chk({31'd0, irq}, 0, "R9 masked pending");
        wr(7'h18, 32'h0); wr(7'h1C, 32'h4); chk({31'd0, irq}, 1, "R9 unmask pending");
        wr(7'h18, 32'hFFFF_FFFB); chk({31'd0, irq}, 0, "R9 mask pending");
    endtask

    task automatic t_both();
        logic [31:0] d;
        do_reset();
        wr(7'h24, 32'h8); wr(7'h4C, 32'h8); wr(7'h20, 32'h0); wr(7'h00, 32'h8);
        pin_in[3] = 1'b1; cyc(4);
        rd(7'h10, d); chk(d, 32'h8, "R7 rising with polarity 0");
        wr(7'h14, 32'h8); rd(7'h10, d); chk(d, 0, "R8 cleared");
        pin_in[3] = 1'b0; cyc(4);
        rd(7'h10, d); chk(d, 32'h8, "R7 falling");
    endtask

    task automatic t_race();
        logic [31:0] d;
        do_reset();
        wr(7'h24, 32'h8); wr(7'h4C, 32'h8); wr(7'h00, 32'h8);
        pin_in[3] = 1'b1; cyc(4);
        rd(7'h10, d); chk(d, 32'h8, "R8 race setup");
        pin_in[3] = 1'b0;
        @(negedge clk);
        wr(7'h14, 32'h8);
        rd(7'h10, d); chk(d, 32'h8, "R8 edge and clear together keep status");
        cyc(2);
        wr(7'h14, 32'h8);
        rd(7'h10, d); chk(d, 0, "R8 clear without edge");
    endtask

    task automatic t_idle_line();
        logic [31:0] d;
        do_reset();
        wr(7'h24, 32'h20); wr(7'h20, 32'h20); wr(7'h1C, 32'h20);
        pin_in[5] = 1'b1; cyc(4);
        rd(7'h10, d); chk(d, 0, "R10 non-source no status");
        rd(7'h0C, d); chk(d, 32'h20, "R10 pin still readable");
        chk({31'd0, irq}, 0, "R10 no irq");
    endtask

    task automatic t_filter();
        logic [31:0] d;
        do_reset();
        wr(7'h28, 32'hFFFF_FFFF); rd(7'h28, d); chk(d, 32'hFFFF_FFFF, "R11 filter readback");
        wr(7'h24, 32'h1); wr(7'h20, 32'h1); wr(7'h00, 32'h1);
        pin_in[0] = 1'b1; cyc(3);
        rd(7'h10, d); chk(d, 32'h1, "R11 filter changes no latency");
    endtask

    initial begin
        t_reset();
        t_regs();
        t_io();
        t_mask();
        t_level();
        t_edge();
        t_both();
        t_race();
        t_idle_line();
        t_filter();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule